// File: doc/BRIEF.md
# Two-Port GPIO with Line Interrupts

This block serves two 8-bit general-purpose I/O ports, A and B, through a byte-wide register bus. Each of the 16 lines can be an input or an output. Every line can also raise an interrupt, and each line has its own configuration for that interrupt.

Line n belongs to port n/8 at bit n mod 8. On the pad side, `pad_i[n]`, `pad_o[n]` and `pad_oe_o[n]` belong to line n. Pad inputs pass through a two-flop synchroniser before any other logic sees them.

Each line has a sensing-mode bit and a polarity bit. The mode bit selects level or edge sensing. The polarity bit selects active-low/falling or active-high/rising. An edge event is latched until software acknowledges it. A level condition follows the synchronised pin. The status bits of both ports are ORed into one interrupt output.

The bus map places port B's register 4 bytes above port A's:

| Register | A | B |
|---|---|---|
| data | 0x00 | 0x04 |
| direction | 0x10 | 0x14 |
| mode | 0x20 | 0x24 |
| polarity | 0x28 | 0x2C |
| enable | 0x30 | 0x34 |
| status (read-only) | 0x38 | 0x3C |
| acknowledge (write-only, reads 0) | 0x40 | 0x44 |

Reads are combinational from `addr_i`. A write happens on the rising clock edge while `wr_en_i` is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A data read at 0x00 (A) or 0x04 (B) returns, for each bit, the data register value on output lines and the synchronised pin on input lines.
- R2: A direction bit of 1 (0x10/0x14) drives `pad_oe_o` high for that line, and `pad_o` shows the data register. A data write changes only the bits whose direction is output.
- R3: A pad change becomes visible in a data read after exactly two rising clock edges.
- R4: In edge mode (mode bit 1), polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. The status bit rises three clock edges after the pad change. An edge of the other polarity latches nothing.
- R5: A latched edge stays pending after the pin returns. It clears on the edge that writes a 1 to its bit of 0x40/0x44. If a new edge arrives in the same cycle as the acknowledge, the new edge wins.
- R6: In level mode (mode bit 0), the status bit is high while the synchronised pin equals the polarity bit (1 = high, 0 = low). Writing the acknowledge bit has no effect on it.
- R7: Status bits (0x38/0x3C) are ANDed with the enable bits (0x30/0x34). A write that clears an enable bit, or that sets the line to level mode, discards the latched edge, so re-enabling the line shows no pending edge.
- R8: `irq_o` is high when any status bit of either port is set.
- R9: After reset, all registers are 0, `pad_oe_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pad_i | input | 16 | Pad input levels, line n at bit n |
| pad_o | output | 16 | Pad output levels |
| pad_oe_o | output | 16 | Pad output enables |
| irq_o | output | 1 | Combined interrupt of both ports |

## Verification
The bench drives the pad with several kinds of stimulus:
- rising and falling pulses on edge-mode lines, including a pulse of the wrong polarity, which shows that polarity selects the edge and that latching outlives the pulse;
- held high and low levels on level-mode lines, checked before and after an acknowledge write, which separates level tracking from latching;
- mixed direction patterns on both ports, which show read-back merging and write masking per bit.

A behavioural reference model is compared on every clock. It confirms the two-edge synchroniser delay and the three-edge edge-status delay. It also confirms that disabling a line drops a pending edge, and that either port alone raises the shared interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W    = 8;
  localparam int PORT_STEP = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h40;

  function automatic logic [ADDR_W-1:0] reg_addr(logic [ADDR_W-1:0] base, int port);
    return base + ADDR_W'(port * PORT_STEP);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         we_data_i,
  input  logic         we_dir_i,
  input  logic         we_mode_i,
  input  logic         we_pol_i,
  input  logic         we_en_i,
  input  logic         we_ack_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] out_q, dir_q, mode_q, pol_q, en_q, pin_d, edge_q;
  logic [W-1:0] mode_n, en_n, keep, ev, ack_m, lvl_hit;

  always_comb begin
    mode_n  = we_mode_i ? wdata_i : mode_q;
    en_n    = we_en_i   ? wdata_i : en_q;
    keep    = mode_n & en_n;
    ev      = (pol_q & pin_i & ~pin_d) | (~pol_q & ~pin_i & pin_d);
    ack_m   = we_ack_i ? wdata_i : '0;
    lvl_hit = ~(pin_i ^ pol_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      pin_d  <= '0;
      edge_q <= '0;
    end else begin
      if (we_data_i) out_q <= (out_q & ~dir_q) | (wdata_i & dir_q);
      if (we_dir_i)  dir_q <= wdata_i;
      if (we_pol_i)  pol_q <= wdata_i;
      mode_q <= mode_n;
      en_q   <= en_n;
      pin_d  <= pin_i;
      // a new edge beats an acknowledge in the same cycle
      edge_q <= keep & (ev | (edge_q & ~ack_m));
    end
  end

  assign out_o     = out_q;
  assign dir_o     = dir_q;
  assign mode_o    = mode_q;
  assign pol_o     = pol_q;
  assign en_o      = en_q;
  assign rd_data_o = (dir_q & out_q) | (~dir_q & pin_i);
  assign stat_o    = en_q & ((mode_q & edge_q) | (~mode_q & lvl_hit));

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_dir_i |=> $stable(dir_q));

  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_data_i |=> $stable(out_q));

  // R5
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(edge_q) & ~$past(ack_m) & en_q & mode_q & ~edge_q) == '0));

  // R4
  edge_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((edge_q & ~$past(edge_q) & ~$past(ev)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORTS = 2,
  localparam int LINES = PORT_W * NPORTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [LINES-1:0]  pad_i,
  output logic [LINES-1:0]  pad_o,
  output logic [LINES-1:0]  pad_oe_o,
  output logic              irq_o
);
  logic [LINES-1:0] pin_s;
  logic [PORT_W-1:0] dir_w [NPORTS];
  logic [PORT_W-1:0] mode_w[NPORTS];
  logic [PORT_W-1:0] pol_w [NPORTS];
  logic [PORT_W-1:0] en_w  [NPORTS];
  logic [PORT_W-1:0] rd_w  [NPORTS];
  logic [PORT_W-1:0] stat_w[NPORTS];
  logic [NPORTS-1:0] port_irq;

  gpio_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_s)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PORT_W-1:0] out_p;

    gpio_port #(.W(PORT_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_s[p*PORT_W +: PORT_W]),
      .we_data_i(wr_en_i && addr_i == reg_addr(OFS_DATA, p)),
      .we_dir_i (wr_en_i && addr_i == reg_addr(OFS_DIR,  p)),
      .we_mode_i(wr_en_i && addr_i == reg_addr(OFS_MODE, p)),
      .we_pol_i (wr_en_i && addr_i == reg_addr(OFS_POL,  p)),
      .we_en_i  (wr_en_i && addr_i == reg_addr(OFS_EN,   p)),
      .we_ack_i (wr_en_i && addr_i == reg_addr(OFS_ACK,  p)),
      .wdata_i  (wdata_i),
      .out_o    (out_p),
      .dir_o    (dir_w[p]),
      .mode_o   (mode_w[p]),
      .pol_o    (pol_w[p]),
      .en_o     (en_w[p]),
      .rd_data_o(rd_w[p]),
      .stat_o   (stat_w[p])
    );

    assign pad_o   [p*PORT_W +: PORT_W] = out_p;
    assign pad_oe_o[p*PORT_W +: PORT_W] = dir_w[p];
    assign port_irq[p] = |stat_w[p];
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (addr_i == reg_addr(OFS_DATA, p)) rdata_o = rd_w[p];
      if (addr_i == reg_addr(OFS_DIR,  p)) rdata_o = dir_w[p];
      if (addr_i == reg_addr(OFS_MODE, p)) rdata_o = mode_w[p];
      if (addr_i == reg_addr(OFS_POL,  p)) rdata_o = pol_w[p];
      if (addr_i == reg_addr(OFS_EN,   p)) rdata_o = en_w[p];
      if (addr_i == reg_addr(OFS_STAT, p)) rdata_o = stat_w[p];
    end
  end

  assign irq_o = |port_irq;

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && pad_oe_o == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr = 0;
  logic [7:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [15:0] pad = 0;
  logic [15:0] pad_o, pad_oe;
  logic        irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // behavioural reference model
  bit [15:0] m_out, m_dir, m_mode, m_pol, m_en, m_edge, m_s1, m_s2, m_prev;

  function automatic bit hit(bit [7:0] base, int line);
    return wr && addr == base + 8'(4 * (line / 8));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_mode = 0; m_pol = 0; m_en = 0;
      m_edge = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      bit [15:0] n_out, n_dir, n_mode, n_pol, n_en, n_edge;
      for (int i = 0; i < 16; i++) begin
        bit w, rise, fall, ev, ack;
        w = wdata[i % 8];
        n_out[i]  = (hit(8'h00, i) && m_dir[i]) ? w : m_out[i];
        n_dir[i]  = hit(8'h10, i) ? w : m_dir[i];
        n_mode[i] = hit(8'h20, i) ? w : m_mode[i];
        n_pol[i]  = hit(8'h28, i) ? w : m_pol[i];
        n_en[i]   = hit(8'h30, i) ? w : m_en[i];
        ack       = hit(8'h40, i) && w;
        rise = m_s2[i] && !m_prev[i];
        fall = !m_s2[i] && m_prev[i];
        ev   = m_pol[i] ? rise : fall;
        n_edge[i] = (n_en[i] && n_mode[i]) ? (ev || (m_edge[i] && !ack)) : 1'b0;
      end
      m_out = n_out; m_dir = n_dir; m_mode = n_mode; m_pol = n_pol;
      m_en = n_en; m_edge = n_edge;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
    end
  end

  function automatic bit [15:0] m_stat();
    bit [15:0] s;
    for (int i = 0; i < 16; i++)
      s[i] = m_en[i] && (m_mode[i] ? m_edge[i] : (m_s2[i] == m_pol[i]));
    return s;
  endfunction

  function automatic bit [7:0] m_rd(bit [7:0] a);
    bit [15:0] dv, st;
    dv = (m_dir & m_out) | (~m_dir & m_s2);
    st = m_stat();
    for (int p = 0; p < 2; p++) begin
      int sh;
      sh = p * 8;
      if (a == 8'h00 + 8'(4*p)) return dv[sh +: 8];
      if (a == 8'h10 + 8'(4*p)) return m_dir[sh +: 8];
      if (a == 8'h20 + 8'(4*p)) return m_mode[sh +: 8];
      if (a == 8'h28 + 8'(4*p)) return m_pol[sh +: 8];
      if (a == 8'h30 + 8'(4*p)) return m_en[sh +: 8];
      if (a == 8'h38 + 8'(4*p)) return st[sh +: 8];
    end
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare against model on every clock, away from the edge
  always @(negedge clk) if (rst_n) begin
    check("R1 read data", 32'(rdata), 32'(m_rd(addr)));
    check("R2 pad_o", 32'(pad_o), 32'(m_out));
    check("R2 pad_oe", 32'(pad_oe), 32'(m_dir));
    check("R8 irq", 32'(irq), 32'(|m_stat()));
  end

  task automatic wr_reg(bit [7:0] a, bit [7:0] d);
    @(posedge clk); #2; wr = 1; addr = a; wdata = d;
    @(posedge clk); #2; wr = 0;
  endtask

  task automatic rd_chk(string tag, bit [7:0] a, bit [7:0] exp);
    @(posedge clk); #2; addr = a; #3;
    check(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic set_pad(bit [15:0] v);
    @(posedge clk); #2; pad = v;
  endtask

  task automatic step_chk(string tag, bit exp);
    @(posedge clk); #3;
    check(tag, 32'(irq), 32'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #3;
    // R9 reset state
    check("R9 irq", 32'(irq), 0);
    check("R9 pad_oe", 32'(pad_oe), 0);
    rd_chk("R9 dir A", 8'h10, 8'h00);
    rd_chk("R9 status B", 8'h3C, 8'h00);

    // R2 direction and masked data write
    wr_reg(8'h10, 8'h0F);
    wr_reg(8'h00, 8'hA5);
    #3;
    check("R2 oe A", 32'(pad_oe[7:0]), 32'h0F);
    check("R2 out A", 32'(pad_o[7:0]), 32'h05);

    // R3 two-edge synchroniser, R1 merged read
    @(posedge clk); #2; addr = 8'h00; pad = 16'h00C0;
    @(posedge clk); #3;
    check("R3 one edge", 32'(rdata), 32'h05);
    @(posedge clk); #3;
    check("R1 R3 merged read", 32'(rdata), 32'hC5);

    // R4 rising edge on line 8
    wr_reg(8'h24, 8'h01);
    wr_reg(8'h2C, 8'h01);
    wr_reg(8'h34, 8'h01);
    set_pad(16'h01C0);
    step_chk("R4 rise edge1", 1'b0);
    step_chk("R4 rise edge2", 1'b0);
    step_chk("R4 rise edge3", 1'b1);
    // R5 latched after pin drops, cleared by ack
    set_pad(16'h00C0);
    idle(4);
    rd_chk("R5 still latched", 8'h3C, 8'h01);
    wr_reg(8'h44, 8'h01);
    rd_chk("R5 acked", 8'h3C, 8'h00);

    // R4 falling edge on line 9, rising pulse ignored
    wr_reg(8'h24, 8'h03);
    wr_reg(8'h34, 8'h03);
    set_pad(16'h02C0);
    idle(4);
    rd_chk("R4 wrong polarity", 8'h3C, 8'h00);
    set_pad(16'h00C0);
    idle(4);
    rd_chk("R4 fall latched", 8'h3C, 8'h02);
    wr_reg(8'h44, 8'h02);
    rd_chk("R5 fall acked", 8'h3C, 8'h00);

    // R6 active-high level on line 0
    wr_reg(8'h10, 8'h0E);
    wr_reg(8'h28, 8'h01);
    wr_reg(8'h30, 8'h01);
    set_pad(16'h00C1);
    step_chk("R6 level edge1", 1'b0);
    step_chk("R6 level edge2", 1'b1);
    wr_reg(8'h40, 8'h01);
    rd_chk("R6 ack ignored", 8'h38, 8'h01);
    set_pad(16'h00C0);
    idle(3);
    rd_chk("R6 level gone", 8'h38, 8'h00);

    // R7 enable gating, active-low level on line 1
    wr_reg(8'h10, 8'h0C);
    rd_chk("R7 masked", 8'h38, 8'h00);
    check("R7 irq masked", 32'(irq), 0);
    wr_reg(8'h30, 8'h03);
    rd_chk("R6 low level", 8'h38, 8'h02);
    check("R8 irq from A", 32'(irq), 1);
    set_pad(16'h00C2);
    idle(3);
    rd_chk("R6 low released", 8'h38, 8'h00);

    // R7 disable discards latched edge on line 8
    set_pad(16'h01C2);
    idle(4);
    rd_chk("R7 latched", 8'h3C, 8'h01);
    check("R8 irq from B", 32'(irq), 1);
    wr_reg(8'h34, 8'h02);
    wr_reg(8'h34, 8'h03);
    rd_chk("R7 discarded", 8'h3C, 8'h00);
    check("R7 irq after discard", 32'(irq), 0);

    // R1 R2 port B data
    wr_reg(8'h14, 8'hF0);
    wr_reg(8'h04, 8'h3C);
    #3;
    check("R2 out B masked", 32'(pad_o[15:8]), 32'h30);
    rd_chk("R1 port B read", 8'h04, 8'h31);

    idle(2);
    summary();
  end
endmodule